// File: doc/BRIEF.md
# Debug RAM bus slave

This block sits behind a debug transport as a slave on a narrow debug bus. It holds a small word-addressed debug RAM that both the bus and a processor hart can reach. A debugger writes a short program into the RAM over the bus. Setting the top bit of a bus write hands that program to the hart by raising a debug interrupt. The hart runs the program out of the RAM, which is visible to it at hart address 0x400. When the program ends, the hart strobes an interrupt-clear input.

Every bus word is 34 bits wide: a 32-bit payload plus two status bits. Responses always carry the current interrupt flag and the hart's halted level. A debugger can therefore poll progress with ordinary reads. Halt=1 with interrupt=1 means the debug program is running. Halt=1 with interrupt=0 means halted. Halt=0 with interrupt=1 means halting. Both zero means running.

The block also decodes a control register and a read-only information register. The information register reports the RAM size and protocol version. Each bus request gets its response one clock later. After any write the block spends one cycle busy.

Top module: `dbg_ram_slave`

## Requirements
- R1: RAM word index i answers at bus address i when i is below 16, and at bus address 0x40 + (i - 16) otherwise. With the default 20 words, indices 16 to 19 sit at 0x40 to 0x43.
- R2: Each accepted request updates `bus_rdata` and `bus_status` at the next clock edge. Bit 33 of the response is the interrupt flag as updated by that request, bit 32 is `hart_halted`, and bits 31:0 are the read word (zero for writes). Bus op codes are 0 idle, 1 read, 2 and 3 write. Status codes are 0 ok, 2 failed and 3 busy.
- R3: A write to a RAM word or to the control register with bit 33 set stores the word and sets `hart_irq`. `hart_irq` stays set until a `hart_irq_clr` cycle with no such write. When a setting write and the clear arrive in the same cycle, the set wins.
- R4: The control register sits at bus address 0x10. Write data bits 17:0 are stored and read back. Bits 31:18 read zero, which includes the bus-error field at 21:19.
- R5: The information register at bus address 0x11 reads as a constant. Bits 15:10 hold the RAM size minus one, bit 5 (authenticated) is 1, bits 1:0 (version) are 1, and all other bits are 0. Writes to it return ok and change nothing.
- R6: A read of an unmapped address returns a zero payload with status ok. A write to an unmapped address returns status 2 and changes no RAM word.
- R7: `bus_busy` is high for exactly the one cycle after each accepted write. A request presented during that cycle is ignored and gets status 3.
- R8: When the hart and the bus touch the same RAM word in one cycle, a hart write overrides a bus write. A bus read in that cycle returns the word as it was before the cycle.
- R9: When `hart_en` is high, `hart_rdata` shows the addressed RAM word one clock later. A hart index at or beyond the RAM size reads as zero.
- R10: After reset, `bus_rdata`, `bus_status`, `bus_busy`, `hart_irq` and `hart_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_op | input | 2 | Bus operation: 0 idle, 1 read, 2/3 write |
| bus_addr | input | ADDR_W | Bus word address |
| bus_wdata | input | 34 | Write word: interrupt bit, halt bit, payload |
| bus_rdata | output | 34 | Response word |
| bus_status | output | 2 | Response status: 0 ok, 2 failed, 3 busy |
| bus_busy | output | 1 | High in the cycle after an accepted write |
| hart_en | input | 1 | Hart RAM access enable |
| hart_we | input | 1 | Hart RAM write enable |
| hart_addr | input | IDX_W | Hart RAM word index |
| hart_wdata | input | 32 | Hart write data |
| hart_rdata | output | 32 | Hart read data, one cycle after the request |
| hart_halted | input | 1 | Hart halted level, reported in bit 32 |
| hart_irq_clr | input | 1 | Hart strobe that ends the debug program |
| hart_irq | output | 1 | Debug interrupt to the hart |

## Verification
A vector table first writes distinct payloads to both RAM regions (including both ends of each region), to unmapped addresses and to the control register. It then reads everything back. This separates the two address mappings and shows that failed writes alias nowhere. Directed sequences then vary the halted level and the interrupt flag to produce all four status-bit combinations in responses. They also issue back-to-back writes to show that the busy cycle drops the second write. Finally, they line hart and bus accesses up on the same word in one cycle, which shows the write priority and the old-value read.

// File: rtl/dbg_ram_slave.sv
module dbg_ram_slave #(
  parameter int RAM_WORDS = 20,
  parameter int ADDR_W    = 7,
  parameter int IDX_W     = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_op,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [33:0]       bus_wdata,
  output logic [33:0]       bus_rdata,
  output logic [1:0]        bus_status,
  output logic              bus_busy,
  input  logic              hart_en,
  input  logic              hart_we,
  input  logic [IDX_W-1:0]  hart_addr,
  input  logic [31:0]       hart_wdata,
  output logic [31:0]       hart_rdata,
  input  logic              hart_halted,
  input  logic              hart_irq_clr,
  output logic              hart_irq
);
  localparam int CTRL_ADDR = 'h10;
  localparam int INFO_ADDR = 'h11;
  localparam int HIGH_BASE = 'h40;
  localparam logic [31:0] INFO_WORD =
    {16'h0, 6'(RAM_WORDS - 1), 4'h0, 1'b1, 1'b0, 2'b00, 2'b01};

  logic [31:0] mem [RAM_WORDS];
  logic [17:0] ctrl_q;

  logic             hit;
  logic [IDX_W-1:0] idx;
  int               a;
  always_comb begin
    a   = int'(bus_addr);
    hit = 1'b0;
    idx = '0;
    if (a < 16 && a < RAM_WORDS) begin
      hit = 1'b1;
      idx = IDX_W'(a);
    end else if (a >= HIGH_BASE && (a - HIGH_BASE + 16) < RAM_WORDS) begin
      hit = 1'b1;
      idx = IDX_W'(a - HIGH_BASE + 16);
    end
  end

  wire is_ctrl = (int'(bus_addr) == CTRL_ADDR);
  wire is_info = (int'(bus_addr) == INFO_ADDR);
  wire req     = (bus_op != 2'd0) && !bus_busy;
  wire wr      = req && bus_op[1];
  wire rd      = req && (bus_op == 2'd1);
  wire irq_set = wr && bus_wdata[33] && (hit || is_ctrl);
  wire irq_d   = irq_set || (hart_irq && !hart_irq_clr);
  wire hart_ok = int'(hart_addr) < RAM_WORDS;

  logic [31:0] rd_word;
  always_comb begin
    if (hit)          rd_word = mem[idx];
    else if (is_ctrl) rd_word = {14'h0, ctrl_q};
    else if (is_info) rd_word = INFO_WORD;
    else              rd_word = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (wr && hit) mem[idx] <= bus_wdata[31:0];
    if (hart_en && hart_we && hart_ok) mem[hart_addr] <= hart_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_status <= 2'd0;
      bus_busy   <= 1'b0;
      hart_irq   <= 1'b0;
      ctrl_q     <= '0;
      hart_rdata <= '0;
    end else begin
      hart_irq <= irq_d;
      bus_busy <= wr;
      if (hart_en) hart_rdata <= hart_ok ? mem[hart_addr] : 32'h0;
      if (wr && is_ctrl) ctrl_q <= bus_wdata[17:0];
      if (bus_op != 2'd0 && bus_busy) begin
        bus_status <= 2'd3;
      end else if (rd) begin
        bus_rdata  <= {irq_d, hart_halted, rd_word};
        bus_status <= 2'd0;
      end else if (wr) begin
        bus_rdata  <= {irq_d, hart_halted, 32'h0};
        bus_status <= (hit || is_ctrl || is_info) ? 2'd0 : 2'd2;
      end else begin
        bus_status <= 2'd0;
      end
    end
  end

  assert_busy_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op[1] && !bus_busy) |=> bus_busy);
  assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> !bus_busy);
  assert_busy_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && bus_op != 2'd0) |=> (bus_status == 2'd3));
  assert_irq_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hart_irq) |-> $past(bus_op[1] && !bus_busy && bus_wdata[33]));
  assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hart_irq_clr && !(bus_op[1] && bus_wdata[33])) |=> !hart_irq);
  assert_halt_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd1 && !bus_busy) |=> (bus_rdata[32] == $past(hart_halted)));
endmodule

// File: tb/dbg_ram_slave_tb.sv
`timescale 1ns/1ps
module dbg_ram_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_op = 2'd0;
  logic [6:0]  bus_addr = '0;
  logic [33:0] bus_wdata = '0;
  logic [33:0] bus_rdata;
  logic [1:0]  bus_status;
  logic        bus_busy;
  logic        hart_en = 1'b0, hart_we = 1'b0;
  logic [4:0]  hart_addr = '0;
  logic [31:0] hart_wdata = '0;
  logic [31:0] hart_rdata;
  logic        hart_halted = 1'b1;
  logic        hart_irq_clr = 1'b0;
  logic        hart_irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dbg_ram_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_status(bus_status),
    .bus_busy(bus_busy), .hart_en(hart_en), .hart_we(hart_we),
    .hart_addr(hart_addr), .hart_wdata(hart_wdata), .hart_rdata(hart_rdata),
    .hart_halted(hart_halted), .hart_irq_clr(hart_irq_clr), .hart_irq(hart_irq));

  localparam int NV = 14;
  // {op, addr, wdata, expected rdata, expected status}
  localparam logic [78:0] VEC [NV] = '{
    {2'd2, 7'h00, 34'h0_11112222, 34'h1_00000000, 2'd0},
    {2'd2, 7'h0F, 34'h0_A5A5A5A5, 34'h1_00000000, 2'd0},
    {2'd3, 7'h40, 34'h0_C0FFEE00, 34'h1_00000000, 2'd0},
    {2'd2, 7'h43, 34'h0_0BADF00D, 34'h1_00000000, 2'd0},
    {2'd2, 7'h44, 34'h0_DEAD0044, 34'h1_00000000, 2'd2},
    {2'd2, 7'h20, 34'h0_DEAD0020, 34'h1_00000000, 2'd2},
    {2'd2, 7'h10, 34'h0_FFFFFFFF, 34'h1_00000000, 2'd0},
    {2'd1, 7'h00, 34'h0,          34'h1_11112222, 2'd0},
    {2'd1, 7'h0F, 34'h0,          34'h1_A5A5A5A5, 2'd0},
    {2'd1, 7'h40, 34'h0,          34'h1_C0FFEE00, 2'd0},
    {2'd1, 7'h43, 34'h0,          34'h1_0BADF00D, 2'd0},
    {2'd1, 7'h44, 34'h0,          34'h1_00000000, 2'd0},
    {2'd1, 7'h11, 34'h0,          34'h1_00004C21, 2'd0},
    {2'd1, 7'h10, 34'h0,          34'h1_0003FFFF, 2'd0}
  };

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] op, input logic [6:0] ad, input logic [33:0] wd);
    @(negedge clk);
    bus_op = op; bus_addr = ad; bus_wdata = wd;
    @(negedge clk);
    bus_op = 2'd0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #20000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rdata", bus_rdata, 34'h0);
    chk("R10 status/busy/irq", {30'h0, bus_status, bus_busy, hart_irq}, 34'h0);
    chk("R10 hart_rdata", {2'b0, hart_rdata}, 34'h0);

    // R1 R4 R5 R6 mapping, registers, unmapped accesses
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][78:77], VEC[i][76:70], VEC[i][69:36]);
      chk($sformatf("R1/R4/R5/R6 vec%0d data", i), bus_rdata, VEC[i][35:2]);
      chk($sformatf("R6 vec%0d status", i), {32'h0, bus_status}, {32'h0, VEC[i][1:0]});
      idle();
    end

    // R3 interrupt raise, status bits R2
    bus(2'd2, 7'h01, 34'h2_00000013);
    chk("R3 R2 write resp irq", bus_rdata, 34'h3_00000000);
    chk("R3 irq set", {33'h0, hart_irq}, 34'h1);
    idle();
    hart_halted = 1'b0;
    bus(2'd1, 7'h01, 34'h0);
    chk("R2 halting bits", bus_rdata, 34'h2_00000013);
    idle();
    @(negedge clk);
    bus_op = 2'd2; bus_addr = 7'h01; bus_wdata = 34'h2_00000017; hart_irq_clr = 1'b1;
    @(negedge clk);
    bus_op = 2'd0; hart_irq_clr = 1'b0;
    chk("R3 set wins over clear", {33'h0, hart_irq}, 34'h1);
    idle();
    @(negedge clk);
    hart_irq_clr = 1'b1;
    @(negedge clk);
    hart_irq_clr = 1'b0;
    chk("R3 cleared", {33'h0, hart_irq}, 34'h0);
    bus(2'd1, 7'h01, 34'h0);
    chk("R2 running bits", bus_rdata, 34'h0_00000017);
    hart_halted = 1'b1;
    idle();

    // R7 busy cycle
    bus(2'd2, 7'h02, 34'h0_AAAA0001);
    chk("R7 busy high", {33'h0, bus_busy}, 34'h1);
    bus_op = 2'd2; bus_addr = 7'h02; bus_wdata = 34'h0_BBBB0002;
    @(negedge clk);
    bus_op = 2'd0;
    chk("R7 busy status", {32'h0, bus_status}, 34'h3);
    chk("R7 busy drops", {33'h0, bus_busy}, 34'h0);
    bus(2'd1, 7'h02, 34'h0);
    chk("R7 ignored write", bus_rdata, 34'h1_AAAA0001);
    idle();

    // R8 collisions
    bus(2'd2, 7'h03, 34'h0_00000003);
    idle();
    @(negedge clk);
    bus_op = 2'd1; bus_addr = 7'h03;
    hart_en = 1'b1; hart_we = 1'b1; hart_addr = 5'd3; hart_wdata = 32'h12345678;
    @(negedge clk);
    bus_op = 2'd0; hart_en = 1'b0; hart_we = 1'b0;
    chk("R8 read old value", bus_rdata, 34'h1_00000003);
    bus(2'd1, 7'h03, 34'h0);
    chk("R8 hart write landed", bus_rdata, 34'h1_12345678);
    @(negedge clk);
    bus_op = 2'd2; bus_addr = 7'h03; bus_wdata = 34'h0_00000055;
    hart_en = 1'b1; hart_we = 1'b1; hart_addr = 5'd3; hart_wdata = 32'h00000066;
    @(negedge clk);
    bus_op = 2'd0; hart_en = 1'b0; hart_we = 1'b0;
    idle();
    bus(2'd1, 7'h03, 34'h0);
    chk("R8 hart write wins", bus_rdata, 34'h1_00000066);

    // R9 hart read port
    @(negedge clk);
    hart_en = 1'b1; hart_addr = 5'd0;
    @(negedge clk);
    chk("R9 hart read", {2'b0, hart_rdata}, 34'h0_11112222);
    hart_addr = 5'd20;
    @(negedge clk);
    hart_en = 1'b0;
    chk("R9 out of range", {2'b0, hart_rdata}, 34'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule